// File: doc/BRIEF.md
# Dual-Processor Display Status and Interrupt Release

This block keeps one display status word for each of two processors. Every copy holds a vertical-blank flag, a line-match flag, two interrupt enables and a 9-bit line compare value. The scan timing sequencer drives three inputs. The first is the current line number. The second is a line-start strobe, on which the flags are updated. The third is an interrupt-issue strobe, which comes a little later in the line.

An enabled event does not raise an interrupt straight away. It is recorded as pending for the processor that owns it. The next interrupt-issue strobe clears every pending bit and sends a one-cycle request pulse for each one. The status flags are live, so software that polls the status word in the gap between line start and interrupt issue already sees the new flag before its interrupt arrives.

Each processor writes its own copy through a shared data bus and a per-processor write enable. Only the control fields can be written; the flags are driven only by the line logic. A read selector picks the copy that drives the read data.

Top module: `disp_stat_irq`

## Requirements
- R1: After synchronous reset, both status words read 0x0000, no pending event is held, and no interrupt pulse is output.
- R2: On a line-start strobe with line number 192, bit 0 (vertical-blank flag) of both words reads 1 from the next cycle.
- R3: On a line-start strobe with line number 262, bit 0 of both words reads 0 from the next cycle.
- R4: On each line-start strobe, bit 2 (line-match flag) of a word becomes 1 if the line number equals that word's compare value, and 0 otherwise. The compare value is {bit 7, bits 15:8}.
- R5: A write changes only bits 3, 5, 7 and 15:8 of the selected word. Bits 0 and 2 keep their values, and bits 1, 4 and 6 always read 0.
- R6: A vertical-blank start with bit 3 set, or a line match with bit 5 set, is held as pending. The interrupt pulse (irq_vblank or irq_vmatch for that processor) is high for exactly the one cycle after the cycle in which irq_phase is sampled high. No pulse appears in the cycle after line start, when the flag already reads 1.
- R7: When the relevant enable bit is clear, the event sets its flag but produces no pulse at the next interrupt-issue strobe.
- R8: The two words and their pending events are independent. A write with wr_en[c] touches only word c, and each pulse appears only on the owning processor's output bit.
- R9: An interrupt-issue strobe clears all pending events, so a second strobe with no new event in between produces no pulse.
- R10: The ninth compare bit (bit 7) takes part in the match. A compare value of 260 matches line 260 and does not match line 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe: line_num holds the new line number |
| irq_phase | input | 1 | One-cycle strobe: release pending interrupts |
| line_num | input | 9 | Current line number |
| wr_en | input | NUM_CPU | Per-processor write enable for its status word |
| wr_data | input | 16 | Write data, shared by all processors |
| rd_sel | input | SEL_W | Selects the status word that drives rd_data |
| rd_data | output | 16 | Live status word of the selected processor |
| irq_vblank | output | NUM_CPU | One-cycle vertical-blank interrupt pulse per processor |
| irq_vmatch | output | NUM_CPU | One-cycle line-match interrupt pulse per processor |

## Verification
The properties assume that the sequencer never raises line_start and irq_phase in the same cycle, and never raises irq_phase on two cycles in a row. Under those conditions a pulse can always be traced back to the issue strobe of the cycle before it, and it can never last two cycles. The stimulus keeps to this: every strobe is a single cycle driven by its own task, with at least one idle cycle after it. Writes can land in any cycle without a line-start strobe, and the property that the flags stay stable between strobes holds whatever the write data is.

// File: rtl/disp_stat_pkg.sv
package disp_stat_pkg;

    localparam int WORD_W = 16;
    localparam int LINE_W = 9;

    // Writable field mask: enables (3, 5), compare high bit (7), compare low byte (15:8)
    localparam logic [WORD_W-1:0] WR_MASK = 16'hFFA8;

    typedef struct packed {
        logic [LINE_W-1:0] cmp;
        logic              vm_en;
        logic              vb_en;
        logic              vm_flag;
        logic              vb_flag;
    } stat_t;

    typedef struct packed {
        logic vb;
        logic vm;
    } irq_pair_t;

    function automatic logic [WORD_W-1:0] pack_word(input stat_t s);
        pack_word = {s.cmp[7:0], s.cmp[8], 1'b0, s.vm_en, 1'b0,
                     s.vb_en, s.vm_flag, 1'b0, s.vb_flag};
    endfunction

    function automatic stat_t merge_write(input stat_t s, input logic [WORD_W-1:0] w);
        stat_t r;
        r         = s;
        r.cmp     = {w[7], w[15:8]};
        r.vb_en   = w[3];
        r.vm_en   = w[5];
        merge_write = r;
    endfunction

endpackage

// File: rtl/disp_line_dec.sv
module disp_line_dec
    import disp_stat_pkg::*;
#(
    parameter int VBL_START = 192,
    parameter int VBL_END   = 262
) (
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    output logic              vb_set,
    output logic              vb_clr
);
    localparam logic [LINE_W-1:0] START_L = LINE_W'(VBL_START);
    localparam logic [LINE_W-1:0] END_L   = LINE_W'(VBL_END);

    always_comb begin
        vb_set = line_start && (line_num == START_L);
        vb_clr = line_start && (line_num == END_L);
    end
endmodule

// File: rtl/disp_stat_reg.sv
module disp_stat_reg
    import disp_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              vb_set,
    input  logic              vb_clr,
    input  logic [LINE_W-1:0] line_num,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output stat_t             stat,
    output irq_pair_t         evt
);
    stat_t stat_q;
    stat_t stat_d;
    logic  hit;

    assign hit = (line_num == stat_q.cmp);

    always_comb begin
        stat_d = stat_q;
        if (wr_en) begin
            stat_d = merge_write(stat_q, wr_data);
        end
        if (line_start) begin
            stat_d.vm_flag = hit;
        end
        if (vb_set) begin
            stat_d.vb_flag = 1'b1;
        end else if (vb_clr) begin
            stat_d.vb_flag = 1'b0;
        end
    end

    always_comb begin
        evt.vb = vb_set && stat_q.vb_en;
        evt.vm = line_start && hit && stat_q.vm_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/disp_irq_pend.sv
module disp_irq_pend
    import disp_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_pair_t evt,
    input  logic      irq_phase,
    output irq_pair_t irq
);
    irq_pair_t pend_q;
    irq_pair_t irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= '0;
        end else begin
            irq_q  <= irq_phase ? pend_q : '0;
            pend_q <= (irq_phase ? '0 : pend_q) | evt;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/disp_stat_irq.sv
module disp_stat_irq
    import disp_stat_pkg::*;
#(
    parameter int NUM_CPU   = 2,
    parameter int VBL_START = 192,
    parameter int VBL_END   = 262,
    localparam int SEL_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic               irq_phase,
    input  logic [8:0]         line_num,
    input  logic [NUM_CPU-1:0] wr_en,
    input  logic [15:0]        wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [15:0]        rd_data,
    output logic [NUM_CPU-1:0] irq_vblank,
    output logic [NUM_CPU-1:0] irq_vmatch
);
    logic                           vb_set;
    logic                           vb_clr;
    logic [NUM_CPU-1:0][WORD_W-1:0] stat_words;

    disp_line_dec #(
        .VBL_START(VBL_START),
        .VBL_END  (VBL_END)
    ) u_dec (
        .line_start(line_start),
        .line_num  (line_num),
        .vb_set    (vb_set),
        .vb_clr    (vb_clr)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        stat_t     stat;
        irq_pair_t evt;
        irq_pair_t irq;

        disp_stat_reg u_reg (
            .clk       (clk),
            .rst       (rst),
            .line_start(line_start),
            .vb_set    (vb_set),
            .vb_clr    (vb_clr),
            .line_num  (line_num),
            .wr_en     (wr_en[c]),
            .wr_data   (wr_data),
            .stat      (stat),
            .evt       (evt)
        );

        disp_irq_pend u_pend (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt),
            .irq_phase(irq_phase),
            .irq      (irq)
        );

        assign stat_words[c]  = pack_word(stat);
        assign irq_vblank[c]  = irq.vb;
        assign irq_vmatch[c]  = irq.vm;
    end

    assign rd_data = stat_words[rd_sel];
endmodule

// File: rtl/disp_stat_irq_chk.sv
module disp_stat_irq_chk #(
    parameter int NUM_CPU   = 2,
    parameter int VBL_START = 192,
    parameter int VBL_END   = 262
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     line_start,
    input logic                     irq_phase,
    input logic [8:0]               line_num,
    input logic [NUM_CPU-1:0][15:0] stat_words,
    input logic [NUM_CPU-1:0]       irq_vblank,
    input logic [NUM_CPU-1:0]       irq_vmatch
);
    localparam logic [8:0] START_L = 9'(VBL_START);
    localparam logic [8:0] END_L   = 9'(VBL_END);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        a_r2_vb_sets: assert property (@(posedge clk) disable iff (rst)
            (line_start && line_num == START_L) |=> stat_words[c][0]);

        a_r3_vb_clears: assert property (@(posedge clk) disable iff (rst)
            (line_start && line_num == END_L) |=> !stat_words[c][0]);

        a_r4_match_sets: assert property (@(posedge clk) disable iff (rst)
            (line_start && line_num == {stat_words[c][7], stat_words[c][15:8]})
            |=> stat_words[c][2]);

        a_r4_miss_clears: assert property (@(posedge clk) disable iff (rst)
            (line_start && line_num != {stat_words[c][7], stat_words[c][15:8]})
            |=> !stat_words[c][2]);

        a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
            !line_start |=> ($stable(stat_words[c][0]) && $stable(stat_words[c][2])));

        a_r6_vb_after_phase: assert property (@(posedge clk) disable iff (rst)
            irq_vblank[c] |-> $past(irq_phase));

        a_r6_vm_after_phase: assert property (@(posedge clk) disable iff (rst)
            irq_vmatch[c] |-> $past(irq_phase));

        a_r6_vb_one_cycle: assert property (@(posedge clk) disable iff (rst)
            irq_vblank[c] |=> !irq_vblank[c]);

        a_r6_vm_one_cycle: assert property (@(posedge clk) disable iff (rst)
            irq_vmatch[c] |=> !irq_vmatch[c]);
    end
endmodule

bind disp_stat_irq disp_stat_irq_chk #(
    .NUM_CPU  (NUM_CPU),
    .VBL_START(VBL_START),
    .VBL_END  (VBL_END)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .irq_phase (irq_phase),
    .line_num  (line_num),
    .stat_words(stat_words),
    .irq_vblank(irq_vblank),
    .irq_vmatch(irq_vmatch)
);

// File: tb/disp_stat_irq_bench.sv
module disp_stat_irq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_start = 1'b0;
    logic       irq_phase = 1'b0;
    logic [8:0] line_num = '0;
    logic [1:0] wr_en = '0;
    logic [15:0] wr_data = '0;
    logic [0:0] rd_sel = '0;
    logic [15:0] rd_data;
    logic [1:0] irq_vblank;
    logic [1:0] irq_vmatch;

    disp_stat_irq u_disp_stat_irq (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .irq_phase (irq_phase),
        .line_num  (line_num),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq_vblank(irq_vblank),
        .irq_vmatch(irq_vmatch)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [1:0] vb;
        logic [1:0] vm;
    } exp_t;
    exp_t sb[$];

    // reference model, built from the requirements
    logic       m_vb [2];
    logic       m_vm [2];
    logic       m_ven[2];
    logic       m_men[2];
    logic [8:0] m_cmp[2];
    logic [1:0] p_vb;
    logic [1:0] p_vm;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_word(input int c);
        model_word = {m_cmp[c][7:0], m_cmp[c][8], 1'b0, m_men[c], 1'b0,
                      m_ven[c], m_vm[c], 1'b0, m_vb[c]};
    endfunction

    task automatic compare_all(input string tag);
        for (int c = 0; c < 2; c++) begin
            rd_sel = c[0:0];
            #1;
            chk(tag, rd_data, model_word(c));
        end
    endtask

    task automatic wr(input int c, input logic [15:0] d, input string tag);
        @(negedge clk);
        wr_en[c] = 1'b1;
        wr_data  = d;
        m_cmp[c] = {d[7], d[15:8]};
        m_ven[c] = d[3];
        m_men[c] = d[5];
        @(negedge clk);
        wr_en = '0;
        compare_all(tag);
    endtask

    task automatic step_line(input logic [8:0] ln, input string tag);
        @(negedge clk);
        line_start = 1'b1;
        line_num   = ln;
        for (int c = 0; c < 2; c++) begin
            if (ln == 9'd192) begin
                m_vb[c] = 1'b1;
                if (m_ven[c]) p_vb[c] = 1'b1;
            end
            if (ln == 9'd262) m_vb[c] = 1'b0;
            m_vm[c] = (ln == m_cmp[c]);
            if (m_vm[c] && m_men[c]) p_vm[c] = 1'b1;
        end
        @(negedge clk);
        line_start = 1'b0;
        // R6: flags are visible already while no pulse is out yet
        chk({tag, " R6 no early pulse"}, {12'd0, irq_vblank, irq_vmatch}, 16'd0);
        compare_all(tag);
    endtask

    task automatic issue(input string tag);
        exp_t e;
        @(negedge clk);
        if ((p_vb | p_vm) != 2'b00) begin
            e.at = cyc + 1;
            e.vb = p_vb;
            e.vm = p_vm;
            sb.push_back(e);
        end
        irq_phase = 1'b1;
        @(negedge clk);
        irq_phase = 1'b0;
        if ((p_vb | p_vm) == 2'b00)
            chk({tag, " no pulse"}, {12'd0, irq_vblank, irq_vmatch}, 16'd0);
        p_vb = '0;
        p_vm = '0;
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && ((irq_vblank | irq_vmatch) != 2'b00)) begin
            if (sb.size() == 0) begin
                chk("R6 R7 R9 unexpected pulse", {12'd0, irq_vblank, irq_vmatch}, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R6 R8 pulse cycle", 16'(cyc), 16'(e.at));
                chk("R6 R8 pulse lines", {12'd0, irq_vblank, irq_vmatch},
                    {12'd0, e.vb, e.vm});
            end
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_vb[c] = 0; m_vm[c] = 0; m_ven[c] = 0; m_men[c] = 0; m_cmp[c] = '0;
        end
        p_vb = '0;
        p_vm = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare_all("R1 reset word");
        chk("R1 reset pulses", {12'd0, irq_vblank, irq_vmatch}, 16'd0);

        wr(0, 16'hFFFF, "R5 R8 write mask");
        wr(0, {8'd100, 8'h28}, "R8 cfg cpu0");
        wr(1, {8'd192, 8'h20}, "R8 cfg cpu1");

        step_line(9'd99,  "R4 miss");
        step_line(9'd100, "R4 hit");
        issue("R6 vmatch cpu0");
        issue("R9 second issue");
        step_line(9'd101, "R4 clear");

        step_line(9'd192, "R2 R7 vblank start");
        issue("R6 R7 R8 vblank and match");
        wr(0, {8'd100, 8'h2D}, "R5 flags read only");

        step_line(9'd262, "R3 vblank end");
        step_line(9'd0,   "R3 wrap");

        wr(1, {8'd4, 8'hA0}, "R10 ninth bit cfg");
        step_line(9'd4,   "R10 low miss");
        step_line(9'd260, "R10 hit");
        issue("R10 pulse");

        wr(0, {8'd100, 8'h00}, "R7 disable");
        step_line(9'd100, "R7 flag only");
        issue("R7 no pulse");

        repeat (3) @(negedge clk);
        chk("R6 all expected pulses seen", 16'(sb.size()), 16'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule